// File: doc/BRIEF.md
# Indexed TLB Entry Write Unit

This block owns the storage of a translation lookaside buffer and carries out the write-by-index operation. A coprocessor instruction word arrives with a strobe, together with the current contents of the staging registers: the slot index, the page-size mask, the high half of the entry (virtual page pair number and address-space identifier) and the two low halves (even and odd page frames with their attribute bits). When the word decodes as the indexed write and coprocessor 0 is usable, the selected slot is overwritten in the same clock edge.

The stored entry is not a plain copy of the staging registers. The page mask clears the matching bits of the virtual page number and of both frame numbers. The two per-half global bits are reduced to a single global bit by AND. A combinational read port returns any slot so that stored contents can be observed. If the instruction is issued while the coprocessor is unusable, nothing is written and a flag is raised. A slot number past the implemented depth is dropped without touching any slot.

A small state machine records the outcome of each strobe for one cycle. The states are ST_IDLE (no write issued in the last cycle), ST_WROTE (a slot was written), ST_DROPPED (an accepted write had an index out of range) and ST_TRAPPED (the coprocessor was unusable). From any state, the next state is chosen by the strobe of the current cycle: no decoded instruction goes to ST_IDLE, an unusable coprocessor goes to ST_TRAPPED, an out-of-range index goes to ST_DROPPED, and any other decoded instruction goes to ST_WROTE. Reset forces ST_IDLE.

Top module: `tlbw_unit`

## Requirements
- R1: An instruction is recognised only when `op_valid` is 1 and `op_word` equals 0x42000002 (bits 31..26 = 010000, bit 25 = 1, bits 24..6 zero, bits 5..0 = 000010). Any other word, or a strobe held low, changes no slot and raises neither output.
- R2: A recognised write with the coprocessor usable and `stage_index` below ENTRIES replaces that slot and leaves every other slot unchanged. `rd_entry` bit layout, MSB first: mask[11:0], vpn2[18:0], asid[7:0], global, odd half {pfn[23:0], cattr[2:0], dirty, valid}, even half with the same layout. The valid bits sit at bit 29 (odd) and bit 0 (even).
- R3: The stored mask and asid equal the staging values. The stored vpn2 equals `stage_vpn2` with bit b cleared wherever mask bit b (b in 0..11) is set.
- R4: The stored global bit is the AND of bit 0 of `stage_lo0` and bit 0 of `stage_lo1`.
- R5: Each staging low half is laid out as {pfn[29:6], cattr[5:3], dirty[2], valid[1], global[0]}. In both stored halves, pfn bit b is zero wherever mask bit b is set. All other pfn bits and cattr, dirty and valid are stored unchanged.
- R6: A recognised write whose index is at or above ENTRIES changes no slot and leaves `wr_done` low. A read of such an index returns zero.
- R7: A recognised instruction with `cu0_enable` low writes nothing. It raises `cop_unusable` for exactly the following cycle, and `wr_done` stays low.
- R8: `wr_done` is 1 for exactly the cycle after each completed write, and 0 otherwise.
- R9: A read of the slot being written, in the cycle of the strobe, returns the old contents. From the next cycle on, it returns the new contents.
- R10: Synchronous reset clears both valid bits of every slot and drives `wr_done` and `cop_unusable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cu0_enable | input | 1 | Coprocessor 0 usable |
| op_valid | input | 1 | Instruction strobe |
| op_word | input | 32 | Instruction word |
| stage_index | input | IDX_W | Slot number from the index staging register |
| stage_mask | input | 12 | Page-size mask |
| stage_vpn2 | input | 19 | Virtual page pair number |
| stage_asid | input | 8 | Address-space identifier |
| stage_lo0 | input | 30 | Even-page low half |
| stage_lo1 | input | 30 | Odd-page low half |
| rd_index | input | IDX_W | Read port slot number |
| rd_entry | output | 98 | Stored contents of slot `rd_index` |
| wr_done | output | 1 | A write completed on the last edge |
| cop_unusable | output | 1 | Coprocessor-unusable exception flag |

## Verification
Page masks are drawn from the legal sizes (4 KB up to 16 MB) and also as arbitrary bit patterns. The legal sizes separate a wrong mask-to-bit alignment from correct clearing, and the arbitrary patterns expose any bit-pair assumption. The four combinations of the two global bits single out an OR or a one-sided copy. Instruction words with a single flipped bit, anywhere among the 32, show whether every field of the decode is compared. Writes with the coprocessor unusable and with indexes past the implemented depth, followed by reads of the target and of an unrelated slot, show whether any state is disturbed. Back-to-back writes to one slot, read during the strobe cycle, tell old contents apart from write-through.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

    localparam int MASK_W  = 12;
    localparam int VPN2_W  = 19;
    localparam int ASID_W  = 8;
    localparam int PFN_W   = 24;
    localparam int CATTR_W = 3;
    localparam int LO_W    = PFN_W + CATTR_W + 3;

    localparam logic [5:0] OPC_COP0  = 6'b010000;
    localparam logic [5:0] FN_WRIDX  = 6'b000010;
    localparam int         ZERO_W    = 19;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [CATTR_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } half_t;

    typedef struct packed {
        half_t h;
        logic  glob;
    } stage_lo_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
        half_t             odd;
        half_t             even;
    } entry_t;

    localparam int ENT_W = $bits(entry_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WROTE,
        ST_DROPPED,
        ST_TRAPPED
    } wstate_t;

endpackage

// File: rtl/tlbw_decode.sv
module tlbw_decode
    import tlbw_pkg::*;
(
    input  logic [31:0] word,
    output logic        is_wridx
);
    logic opc_ok, co_ok, zero_ok, fn_ok;

    always_comb begin
        opc_ok   = (word[31:26] == OPC_COP0);
        co_ok    = word[25];
        zero_ok  = (word[24:6] == '0);
        fn_ok    = (word[5:0] == FN_WRIDX);
        is_wridx = opc_ok && co_ok && zero_ok && fn_ok;
    end
endmodule

// File: rtl/tlbw_form.sv
module tlbw_form
    import tlbw_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    input  logic [VPN2_W-1:0] vpn2,
    input  logic [ASID_W-1:0] asid,
    input  logic [LO_W-1:0]   lo0,
    input  logic [LO_W-1:0]   lo1,
    output entry_t            ent
);
    stage_lo_t          s0, s1;
    logic [PFN_W-1:0]   pfn_keep;
    logic [VPN2_W-1:0]  vpn_keep;

    assign s0 = lo0;
    assign s1 = lo1;

    for (genvar b = 0; b < PFN_W; b++) begin : g_pfn_keep
        if (b < MASK_W) begin : g_masked
            assign pfn_keep[b] = ~mask[b];
        end else begin : g_open
            assign pfn_keep[b] = 1'b1;
        end
    end

    for (genvar b = 0; b < VPN2_W; b++) begin : g_vpn_keep
        if (b < MASK_W) begin : g_masked
            assign vpn_keep[b] = ~mask[b];
        end else begin : g_open
            assign vpn_keep[b] = 1'b1;
        end
    end

    always_comb begin
        ent            = '0;
        ent.mask       = mask;
        ent.vpn2       = vpn2 & vpn_keep;
        ent.asid       = asid;
        ent.glob       = s0.glob & s1.glob;
        ent.even       = s0.h;
        ent.even.pfn   = s0.h.pfn & pfn_keep;
        ent.odd        = s1.h;
        ent.odd.pfn    = s1.h.pfn & pfn_keep;
    end
endmodule

// File: rtl/tlbw_array.sv
module tlbw_array
    import tlbw_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  entry_t           wdata,
    input  logic [IDX_W-1:0] raddr,
    output entry_t           rdata
);
    localparam int SPAN = 2 ** IDX_W;

    entry_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i].even.valid <= 1'b0;
                mem[i].odd.valid  <= 1'b0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    if (ENTRIES < SPAN) begin : g_partial
        always_comb begin
            if (32'(raddr) < ENTRIES) rdata = mem[raddr];
            else                      rdata = '0;
        end
    end else begin : g_full
        assign rdata = mem[raddr];
    end
endmodule

// File: rtl/tlbw_unit.sv
module tlbw_unit
    import tlbw_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cu0_enable,
    input  logic                  op_valid,
    input  logic [31:0]           op_word,
    input  logic [IDX_W-1:0]      stage_index,
    input  logic [MASK_W-1:0]     stage_mask,
    input  logic [VPN2_W-1:0]     stage_vpn2,
    input  logic [ASID_W-1:0]     stage_asid,
    input  logic [LO_W-1:0]       stage_lo0,
    input  logic [LO_W-1:0]       stage_lo1,
    input  logic [IDX_W-1:0]      rd_index,
    output logic [ENT_W-1:0]      rd_entry,
    output logic                  wr_done,
    output logic                  cop_unusable
);
    wstate_t state_q, state_d;
    logic    is_wridx, in_range, issue, do_write;
    entry_t  new_ent, rd_ent;

    tlbw_decode u_dec (
        .word     (op_word),
        .is_wridx (is_wridx)
    );

    tlbw_form u_form (
        .mask (stage_mask),
        .vpn2 (stage_vpn2),
        .asid (stage_asid),
        .lo0  (stage_lo0),
        .lo1  (stage_lo1),
        .ent  (new_ent)
    );

    tlbw_array #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (do_write),
        .waddr (stage_index),
        .wdata (new_ent),
        .raddr (rd_index),
        .rdata (rd_ent)
    );

    assign rd_entry = rd_ent;
    assign issue    = op_valid && is_wridx;
    assign in_range = (32'(stage_index) < ENTRIES);
    assign do_write = issue && cu0_enable && in_range;

    always_comb begin
        if (!issue)           state_d = ST_IDLE;
        else if (!cu0_enable) state_d = ST_TRAPPED;
        else if (!in_range)   state_d = ST_DROPPED;
        else                  state_d = ST_WROTE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        wr_done      = 1'b0;
        cop_unusable = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_WROTE:   wr_done      = 1'b1;
            ST_DROPPED: ;
            ST_TRAPPED: cop_unusable = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/tlbw_checker.sv
module tlbw_checker
    import tlbw_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             cu0_enable,
    input logic             op_valid,
    input logic [IDX_W-1:0] stage_index,
    input logic [LO_W-1:0]  stage_lo0,
    input logic [LO_W-1:0]  stage_lo1,
    input logic [IDX_W-1:0] rd_index,
    input logic [ENT_W-1:0] rd_entry,
    input logic             wr_done,
    input logic             cop_unusable
);
    entry_t seen;
    assign seen = rd_entry;

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wr_done && cop_unusable));

    a_r7_trap_cause: assert property (@(posedge clk) disable iff (rst)
        cop_unusable |-> $past(op_valid && !cu0_enable));

    a_r8_done_cause: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> $past(op_valid && cu0_enable && (32'(stage_index) < ENTRIES)));

    a_r6_drop_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(32'(stage_index) >= ENTRIES) |-> !wr_done);

    a_r4_global_and: assert property (@(posedge clk) disable iff (rst)
        (wr_done && (rd_index == $past(stage_index)))
            |-> (seen.glob == ($past(stage_lo0[0]) & $past(stage_lo1[0]))));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(op_valid) && $stable(rd_index)) |-> $stable(rd_entry));

    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_done && !cop_unusable));
endmodule

bind tlbw_unit tlbw_checker #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
) u_tlbw_chk (
    .clk          (clk),
    .rst          (rst),
    .cu0_enable   (cu0_enable),
    .op_valid     (op_valid),
    .stage_index  (stage_index),
    .stage_lo0    (stage_lo0),
    .stage_lo1    (stage_lo1),
    .rd_index     (rd_index),
    .rd_entry     (rd_entry),
    .wr_done      (wr_done),
    .cop_unusable (cop_unusable)
);

// File: tb/test_tlbw_unit.sv
module test_tlbw_unit;
    import tlbw_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          N_ENT      = 48;
    localparam int          IW         = 6;
    localparam logic [31:0] OPW        = 32'h4200_0002;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cu0_enable = 1'b0;
    logic              op_valid = 1'b0;
    logic [31:0]       op_word = '0;
    logic [IW-1:0]     stage_index = '0;
    logic [MASK_W-1:0] stage_mask = '0;
    logic [VPN2_W-1:0] stage_vpn2 = '0;
    logic [ASID_W-1:0] stage_asid = '0;
    logic [LO_W-1:0]   stage_lo0 = '0;
    logic [LO_W-1:0]   stage_lo1 = '0;
    logic [IW-1:0]     rd_index = '0;
    logic [ENT_W-1:0]  rd_entry;
    logic              wr_done;
    logic              cop_unusable;

    tlbw_unit #(.ENTRIES(N_ENT), .IDX_W(IW)) i_tlbw_unit (
        .clk(clk), .rst(rst), .cu0_enable(cu0_enable), .op_valid(op_valid),
        .op_word(op_word), .stage_index(stage_index), .stage_mask(stage_mask),
        .stage_vpn2(stage_vpn2), .stage_asid(stage_asid), .stage_lo0(stage_lo0),
        .stage_lo1(stage_lo1), .rd_index(rd_index), .rd_entry(rd_entry),
        .wr_done(wr_done), .cop_unusable(cop_unusable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int               n_cmp = 0;
    int               n_bad = 0;
    logic [ENT_W-1:0] model [N_ENT];
    bit               wr_seen [N_ENT];

    function automatic logic [ENT_W-1:0] expect_entry(
        input logic [MASK_W-1:0] m, input logic [VPN2_W-1:0] vp,
        input logic [ASID_W-1:0] as, input logic [LO_W-1:0] l0,
        input logic [LO_W-1:0] l1);
        logic [PFN_W-1:0]  p0, p1;
        logic [VPN2_W-1:0] v;
        p0 = l0[29:6];
        p1 = l1[29:6];
        v  = vp;
        for (int b = 0; b < MASK_W; b++) begin
            if (m[b]) begin
                p0[b] = 1'b0;
                p1[b] = 1'b0;
                v[b]  = 1'b0;
            end
        end
        return {m, v, as, l0[0] & l1[0], p1, l1[5:1], p0, l0[5:1]};
    endfunction

    function automatic logic [MASK_W-1:0] legal_mask(input int k);
        return MASK_W'((1 << (2 * k)) - 1);
    endfunction

    task automatic check(input logic [127:0] act, input logic [127:0] exp,
                         input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_slot(input int idx, input string req);
        rd_index = IW'(idx);
        #1;
        if (idx >= N_ENT)      check(128'(rd_entry), 128'(0), req);
        else if (wr_seen[idx]) check(128'(rd_entry), 128'(model[idx]), req);
        else                   check(128'({rd_entry[29], rd_entry[0]}), 128'(0), req);
    endtask

    task automatic run_op(input logic ov, input logic [31:0] w, input logic cu,
                          input int idx, input logic [MASK_W-1:0] m,
                          input logic [VPN2_W-1:0] vp, input logic [ASID_W-1:0] as,
                          input logic [LO_W-1:0] l0, input logic [LO_W-1:0] l1);
        logic hit, exp_done, exp_trap;
        @(negedge clk);
        op_valid = ov; op_word = w; cu0_enable = cu; stage_index = IW'(idx);
        stage_mask = m; stage_vpn2 = vp; stage_asid = as;
        stage_lo0 = l0; stage_lo1 = l1;
        hit      = ov && (w == OPW);
        exp_done = hit && cu && (idx < N_ENT);
        exp_trap = hit && !cu;
        check_slot(idx, "R9 old contents during strobe");
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        check(128'(wr_done), 128'(exp_done), "R8 wr_done");
        check(128'(cop_unusable), 128'(exp_trap), "R7 cop_unusable");
        if (exp_done) begin
            model[idx]   = expect_entry(m, vp, as, l0, l1);
            wr_seen[idx] = 1'b1;
            check_slot(idx, "R2 R3 R4 R5 written slot");
        end else begin
            check_slot(idx, "R1 R6 R7 slot untouched");
        end
        check_slot(int'($urandom_range(0, N_ENT - 1)), "R2 other slot");
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N_ENT; i++) wr_seen[i] = 1'b0;
        #1;
        check(128'({wr_done, cop_unusable}), 128'(0), "R10 outputs low");
        for (int i = 0; i < N_ENT; i++) check_slot(i, "R10 valid bits cleared");
    endtask

    function automatic logic [LO_W-1:0] rnd_lo();
        return LO_W'({$urandom(), $urandom()});
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        run_op(1, OPW, 1, 0, 12'h000, 19'h7ffff, 8'hA5, 30'h3fffffff, 30'h3fffffff);
        run_op(1, OPW, 1, N_ENT-1, 12'hfff, 19'h7ffff, 8'h3c, 30'h3fffffff, 30'h3fffffff);
        run_op(1, OPW, 1, 5, 12'h003, 19'h12345, 8'h01, 30'h2aaaaaab, 30'h15555554);
        run_op(1, OPW, 1, 6, 12'h00f, 19'h54321, 8'h02, 30'h15555554, 30'h2aaaaaab);
        run_op(1, OPW, 1, 7, 12'h03f, 19'h0f0f0, 8'h03, 30'h00000001, 30'h00000001);
        run_op(1, OPW, 1, 8, 12'h5a5, 19'h7ffff, 8'h04, 30'h3fffffff, 30'h3fffffff);
        run_op(0, OPW, 1, 9, 12'h000, 19'h11111, 8'h05, 30'h3fffffff, 30'h3fffffff);
        run_op(1, OPW, 0, 10, 12'h000, 19'h22222, 8'h06, 30'h3fffffff, 30'h3fffffff);
        run_op(1, OPW, 1, 50, 12'h000, 19'h33333, 8'h07, 30'h3fffffff, 30'h3fffffff);
        run_op(1, OPW, 1, 63, 12'h000, 19'h44444, 8'h08, 30'h3fffffff, 30'h3fffffff);
        for (int b = 0; b < 32; b++)
            run_op(1, OPW ^ (32'd1 << b), 1, 11, 12'h000, 19'h55555, 8'h09,
                   30'h3fffffff, 30'h3fffffff);
        run_op(1, OPW, 1, 12, 12'h000, 19'h00001, 8'h0a, 30'h00000003, 30'h00000003);
        run_op(1, OPW, 1, 12, 12'h0ff, 19'h7fffe, 8'h0b, 30'h3ffffffe, 30'h3ffffffe);

        for (int n = 0; n < 400; n++) begin
            int          kind, idx;
            logic [31:0] w;
            logic [MASK_W-1:0] m;
            kind = int'($urandom_range(0, 9));
            idx  = (kind == 8) ? int'($urandom_range(N_ENT, 63))
                               : int'($urandom_range(0, N_ENT - 1));
            w    = (kind == 9) ? (OPW ^ (32'd1 << $urandom_range(0, 31))) : OPW;
            m    = ($urandom_range(0, 3) == 0) ? MASK_W'($urandom())
                                               : legal_mask(int'($urandom_range(0, 6)));
            run_op(kind != 7, w, kind != 6, idx, m, VPN2_W'($urandom()),
                   ASID_W'($urandom()), rnd_lo(), rnd_lo());
        end

        do_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule